// File: doc/BRIEF.md
# Processor Fault Entry Unit

This block sits beside a CPU pipeline and carries out the hardware part of entering privileged handler code. When the pipeline reports a fault, the block takes in the fault kind, the PC of the faulting instruction, the data virtual address, the instruction word and the access flags. From these it picks a fixed handler offset for the kind and sends the pipeline to the privileged base register plus that offset. On the same clock edge it records the exception return address and, for translation faults, fills in the diagnostic registers that the handler reads.

Handler software reaches every context register, and one event counter per fault kind, through a small register port. Writes go in on a clock edge and reads are combinational. The block has no TLB, no page walker and no flush logic. It only records the fault state and supplies the redirect.

Top module: `fault_entry_unit`

## Requirements
- R1: After reset every context register and every event counter reads 0, and `redirect_o` is low.
- R2: The fault kind code picks the handler offset: 0 reset 0x0001, 1 interrupt 0x0101, 2 instruction-access violation 0x0081, 3 instruction-translation miss 0x0181, 4 single data miss 0x0201, 5 double data miss 0x0281, 6 unaligned data access 0x0301, 7 data page fault 0x0381, 8 data access violation 0x0381, 9 machine check 0x0401, 10 illegal opcode 0x0481, 11 arithmetic 0x0501, 12 integer overflow 0x0501, 13 float enable 0x0581, 14 vector enable 0x0581, 15 privileged call 0x2001.
- R3: The clock edge that samples `flt_valid` high raises `redirect_o` for exactly one cycle. With it, `redirect_pc_o` carries the privileged base register value, as it stood before that edge, plus the offset.
- R4: The exception address register takes the faulting PC if the kind asks for a restart address, or if PC bits 1:0 are both 0. Otherwise it keeps its old value. Kinds 1, 11, 12 and 15 do not ask for a restart address.
- R5: For the trap kinds 12 and 15, the value chosen under R4 is stored plus 4.
- R6: A data translation fault (kinds 4 to 8) latches the virtual address into the data-VA register. It also latches a status word: instruction bits 31:26 (opcode) go to status bits 16:11, instruction bits 25:21 (Ra) go to status bits 10:6, and the access flags go to status bits 5:0.
- R7: The same capture sets the data formatted-address register to the data page-table base OR ((VA >> 13) << 3).
- R8: When `flt_pte_load` or `flt_prefetch` is high, the data-VA, status and data formatted-address registers stay unchanged.
- R9: An instruction translation fault (kinds 2 and 3) writes the PC to the instruction-tag register. It sets the instruction formatted-address register to the instruction page-table base OR ((PC >> 13) << 3).
- R10: Each fault increments the event counter of its own kind, which reads at address 16 + kind. Writes to counter addresses have no effect.
- R11: Register addresses are: 0 privileged base, 1 exception address, 2 data VA, 3 status, 4 data formatted address, 5 data page-table base, 6 instruction tag, 7 instruction formatted address, 8 instruction page-table base. All of these can be written and read back. A write in a cycle with `flt_valid` high is dropped.
- R12: A fault of any other kind (0, 1, 9 to 15) leaves all diagnostic registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_valid | input | 1 | Single-cycle fault report strobe |
| flt_kind | input | 4 | Fault kind code |
| flt_pc | input | AW | PC of the faulting instruction |
| flt_vaddr | input | AW | Data virtual address |
| flt_insn | input | 32 | Instruction word |
| flt_flags | input | 6 | Access flags |
| flt_pte_load | input | 1 | Access is a page-table-entry load |
| flt_prefetch | input | 1 | Access is a prefetch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| redirect_o | output | 1 | Handler redirect strobe |
| redirect_pc_o | output | AW | Handler entry PC |

## Verification
The redirect is exercised with all sixteen kinds in turn, which tells apart the shared offsets from the distinct ones and the trap kinds from the others. For the return address, the bench uses aligned and misaligned PCs with both restart and non-restart kinds. This separates "load the PC" from "keep the old value" and from "keep the old value plus 4". For diagnostic capture, it compares a plain data fault against page-table-entry loads, prefetches, instruction faults and non-translation faults. This shows which register group each one touches. A register write that coincides with a fault shows that the capture wins.

// File: rtl/fe_pkg.sv
// Shared types for the fault entry unit: fault kind codes, register
// addresses and the per-kind attribute record.
package fe_pkg;
    localparam int NUM_KINDS = 16;
    localparam int KIND_W    = 4;
    localparam int VEC_W     = 14;
    localparam int RADDR_W   = 5;
    localparam int STAT_W    = 17;

    typedef enum logic [KIND_W-1:0] {
        FK_RESET  = 4'd0,  FK_INTR   = 4'd1,  FK_IACV  = 4'd2,  FK_IMISS = 4'd3,
        FK_DMISS1 = 4'd4,  FK_DMISS2 = 4'd5,  FK_UNALN = 4'd6,  FK_DPAGE = 4'd7,
        FK_DACV   = 4'd8,  FK_MCHK   = 4'd9,  FK_OPDEC = 4'd10, FK_ARITH = 4'd11,
        FK_IOVF   = 4'd12, FK_FEN    = 4'd13, FK_VEN   = 4'd14, FK_PAL   = 4'd15
    } fault_kind_e;

    localparam logic [RADDR_W-1:0] RA_BASE  = 5'd0;
    localparam logic [RADDR_W-1:0] RA_EXC   = 5'd1;
    localparam logic [RADDR_W-1:0] RA_DVA   = 5'd2;
    localparam logic [RADDR_W-1:0] RA_STAT  = 5'd3;
    localparam logic [RADDR_W-1:0] RA_DFORM = 5'd4;
    localparam logic [RADDR_W-1:0] RA_DPTB  = 5'd5;
    localparam logic [RADDR_W-1:0] RA_ITAG  = 5'd6;
    localparam logic [RADDR_W-1:0] RA_IFORM = 5'd7;
    localparam logic [RADDR_W-1:0] RA_IPTB  = 5'd8;

    typedef struct packed {
        logic [VEC_W-1:0] vec;      // handler offset
        logic             restart;  // load return address unconditionally
        logic             skip;     // trap: step past faulting instruction
        logic             dtb;      // data translation fault
        logic             itb;      // instruction translation fault
    } fault_attr_t;
endpackage

// File: rtl/fe_vector_lut.sv
// Fault attribute lookup: maps a fault kind to its handler offset,
// return-address rule and translation class. Purely combinational.
// Assumes the kind code covers all 16 values.
module fe_vector_lut
    import fe_pkg::*;
(
    input  fault_kind_e kind,
    output fault_attr_t attr
);
    // Table lookup of per-kind attributes
    always_comb begin
        attr = '{vec: '0, restart: 1'b1, skip: 1'b0, dtb: 1'b0, itb: 1'b0};
        case (kind)
            FK_RESET:  attr.vec = 14'h0001;
            FK_INTR:   begin attr.vec = 14'h0101; attr.restart = 1'b0; end
            FK_IACV:   begin attr.vec = 14'h0081; attr.itb = 1'b1; end
            FK_IMISS:  begin attr.vec = 14'h0181; attr.itb = 1'b1; end
            FK_DMISS1: begin attr.vec = 14'h0201; attr.dtb = 1'b1; end
            FK_DMISS2: begin attr.vec = 14'h0281; attr.dtb = 1'b1; end
            FK_UNALN:  begin attr.vec = 14'h0301; attr.dtb = 1'b1; end
            FK_DPAGE:  begin attr.vec = 14'h0381; attr.dtb = 1'b1; end
            FK_DACV:   begin attr.vec = 14'h0381; attr.dtb = 1'b1; end
            FK_MCHK:   attr.vec = 14'h0401;
            FK_OPDEC:  attr.vec = 14'h0481;
            FK_ARITH:  begin attr.vec = 14'h0501; attr.restart = 1'b0; end
            FK_IOVF:   begin attr.vec = 14'h0501; attr.restart = 1'b0; attr.skip = 1'b1; end
            FK_FEN:    attr.vec = 14'h0581;
            FK_VEN:    attr.vec = 14'h0581;
            FK_PAL:    begin attr.vec = 14'h2001; attr.restart = 1'b0; attr.skip = 1'b1; end
            default:   attr.vec = '0;
        endcase
    end
endmodule

// File: rtl/fe_event_counters.sv
// Per-kind fault event counters. Each accepted fault increments the
// counter of its kind; counters wrap at 2**CNT_W. Not software-writable.
module fe_event_counters #(
    parameter int NUM = 16,
    parameter int CNT_W = 16,
    localparam int SEL_W = $clog2(NUM)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc,
    input  logic [SEL_W-1:0]          sel,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        // Count events of kind g
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (inc && sel == SEL_W'(g))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end
endmodule

// File: rtl/fe_ctx_regs.sv
// Context register file of the fault entry unit. Captures the return
// address and translation diagnostics on a fault and otherwise accepts
// software writes. A fault capture drops a concurrent write.
// Assumes AW >= STAT_W and AW > PAGE_SHIFT.
module fe_ctx_regs
    import fe_pkg::*;
#(
    parameter int AW = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  fault_attr_t        attr,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      va,
    input  logic [31:0]        insn,
    input  logic [5:0]         flags,
    input  logic               pte_load,
    input  logic               prefetch,
    input  logic               we,
    input  logic [RADDR_W-1:0] waddr,
    input  logic [AW-1:0]      wdata,
    output logic [AW-1:0]      priv_base_q,
    output logic [AW-1:0]      exc_addr_q,
    output logic [AW-1:0]      d_va_q,
    output logic [AW-1:0]      d_stat_q,
    output logic [AW-1:0]      d_form_q,
    output logic [AW-1:0]      d_ptb_q,
    output logic [AW-1:0]      i_tag_q,
    output logic [AW-1:0]      i_form_q,
    output logic [AW-1:0]      i_ptb_q
);
    logic [AW-1:0] exc_pick, exc_next;
    logic          d_latch;
    logic          unused_insn_low;

    assign unused_insn_low = ^insn[20:0];

    // Return address: choose PC or keep, then step past on traps
    always_comb begin
        exc_pick = (attr.restart || pc[1:0] == 2'b00) ? pc : exc_addr_q;
        exc_next = attr.skip ? exc_pick + AW'(4) : exc_pick;
    end

    assign d_latch = attr.dtb && !pte_load && !prefetch;

    // Capture on fault, else software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_base_q <= '0; exc_addr_q <= '0; d_va_q <= '0;
            d_stat_q <= '0; d_form_q <= '0; d_ptb_q <= '0;
            i_tag_q <= '0; i_form_q <= '0; i_ptb_q <= '0;
        end else if (cap) begin
            exc_addr_q <= exc_next;
            if (d_latch) begin
                d_va_q   <= va;
                d_stat_q <= {{(AW-STAT_W){1'b0}}, insn[31:26], insn[25:21], flags};
                d_form_q <= d_ptb_q | ((va >> PAGE_SHIFT) << 3);
            end
            if (attr.itb) begin
                i_tag_q  <= pc;
                i_form_q <= i_ptb_q | ((pc >> PAGE_SHIFT) << 3);
            end
        end else if (we) begin
            case (waddr)
                RA_BASE:  priv_base_q <= wdata;
                RA_EXC:   exc_addr_q  <= wdata;
                RA_DVA:   d_va_q      <= wdata;
                RA_STAT:  d_stat_q    <= wdata;
                RA_DFORM: d_form_q    <= wdata;
                RA_DPTB:  d_ptb_q     <= wdata;
                RA_ITAG:  i_tag_q     <= wdata;
                RA_IFORM: i_form_q    <= wdata;
                RA_IPTB:  i_ptb_q     <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/fault_entry_unit.sv
// Fault entry unit top: looks up the fault attributes, updates the
// context registers and counters, and issues a one-cycle redirect to
// the privileged base plus handler offset. Assumes CNT_W <= AW.
module fault_entry_unit
    import fe_pkg::*;
#(
    parameter int AW = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flt_valid,
    input  logic [KIND_W-1:0]  flt_kind,
    input  logic [AW-1:0]      flt_pc,
    input  logic [AW-1:0]      flt_vaddr,
    input  logic [31:0]        flt_insn,
    input  logic [5:0]         flt_flags,
    input  logic               flt_pte_load,
    input  logic               flt_prefetch,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [AW-1:0]      reg_wdata,
    output logic [AW-1:0]      reg_rdata,
    output logic               redirect_o,
    output logic [AW-1:0]      redirect_pc_o
);
    fault_kind_e kind;
    fault_attr_t attr;
    logic [AW-1:0] priv_base_q, exc_addr_q, d_va_q, d_stat_q, d_form_q;
    logic [AW-1:0] d_ptb_q, i_tag_q, i_form_q, i_ptb_q;
    logic [NUM_KINDS-1:0][CNT_W-1:0] ev_cnt;

    assign kind = fault_kind_e'(flt_kind);

    fe_vector_lut u_lut (.kind(kind), .attr(attr));

    fe_ctx_regs #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cap(flt_valid), .attr(attr),
        .pc(flt_pc), .va(flt_vaddr), .insn(flt_insn), .flags(flt_flags),
        .pte_load(flt_pte_load), .prefetch(flt_prefetch),
        .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
        .priv_base_q(priv_base_q), .exc_addr_q(exc_addr_q), .d_va_q(d_va_q),
        .d_stat_q(d_stat_q), .d_form_q(d_form_q), .d_ptb_q(d_ptb_q),
        .i_tag_q(i_tag_q), .i_form_q(i_form_q), .i_ptb_q(i_ptb_q)
    );

    fe_event_counters #(.NUM(NUM_KINDS), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(flt_valid), .sel(flt_kind), .cnt(ev_cnt)
    );

    // Redirect strobe and handler entry PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            redirect_o <= flt_valid;
            if (flt_valid)
                redirect_pc_o <= priv_base_q + {{(AW-VEC_W){1'b0}}, attr.vec};
        end
    end

    // Software read mux over context registers and counters
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[RADDR_W-1]) begin
            reg_rdata = {{(AW-CNT_W){1'b0}}, ev_cnt[reg_addr[KIND_W-1:0]]};
        end else begin
            case (reg_addr)
                RA_BASE:  reg_rdata = priv_base_q;
                RA_EXC:   reg_rdata = exc_addr_q;
                RA_DVA:   reg_rdata = d_va_q;
                RA_STAT:  reg_rdata = d_stat_q;
                RA_DFORM: reg_rdata = d_form_q;
                RA_DPTB:  reg_rdata = d_ptb_q;
                RA_ITAG:  reg_rdata = i_tag_q;
                RA_IFORM: reg_rdata = i_form_q;
                RA_IPTB:  reg_rdata = i_ptb_q;
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fault_entry_chk.sv
// Property checker for the fault entry unit, bound into the top.
module fault_entry_chk
    import fe_pkg::*;
#(
    parameter int AW = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flt_valid,
    input logic [KIND_W-1:0]  flt_kind,
    input logic [AW-1:0]      flt_pc,
    input logic               flt_pte_load,
    input logic               flt_prefetch,
    input logic               reg_we,
    input logic               redirect_o,
    input logic [AW-1:0]      redirect_pc_o,
    input logic [AW-1:0]      priv_base_q,
    input logic [AW-1:0]      d_va_q,
    input logic [AW-1:0]      i_tag_q
);
    p_redirect_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> redirect_o);

    p_redirect_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> !redirect_o);

    p_call_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_kind == 4'd15) |=> redirect_pc_o == $past(priv_base_q) + AW'(14'h2001));

    p_write_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && reg_we) |=> priv_base_q == $past(priv_base_q));

    p_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (flt_pte_load || flt_prefetch)) |=> d_va_q == $past(d_va_q));

    p_itag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && (flt_kind == 4'd2 || flt_kind == 4'd3)) |=> i_tag_q == $past(flt_pc));
endmodule

bind fault_entry_unit fault_entry_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_fault_entry_unit.sv
module tb_fault_entry_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flt_valid = 1'b0;
    logic [3:0]    flt_kind = '0;
    logic [AW-1:0] flt_pc = '0, flt_vaddr = '0;
    logic [31:0]   flt_insn = '0;
    logic [5:0]    flt_flags = '0;
    logic          flt_pte_load = 1'b0, flt_prefetch = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          redirect_o;
    logic [AW-1:0] redirect_pc_o;

    int checks = 0, fails = 0;
    int exp_cnt [16];
    logic [31:0] base_v, dptb_v, iptb_v;

    always #2 clk = ~clk;

    fault_entry_unit dut (.*);

    function automatic logic [31:0] vec_of(int k);
        case (k)
            0: return 32'h0001;  1: return 32'h0101;  2: return 32'h0081;  3: return 32'h0181;
            4: return 32'h0201;  5: return 32'h0281;  6: return 32'h0301;  7: return 32'h0381;
            8: return 32'h0381;  9: return 32'h0401; 10: return 32'h0481; 11: return 32'h0501;
            12: return 32'h0501; 13: return 32'h0581; 14: return 32'h0581; default: return 32'h2001;
        endcase
    endfunction

    function automatic bit skip_of(int k);
        return k == 12 || k == 15;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    // Raise one fault; check redirect strobe and entry PC (R3, R2)
    task automatic do_fault(int k, logic [31:0] pc, logic [31:0] va = 0,
                            logic [31:0] insn = 0, logic [5:0] fl = 0,
                            logic pte = 0, logic pf = 0, logic we = 0,
                            logic [4:0] wa = 0, logic [31:0] wd = 0);
        @(negedge clk);
        flt_valid = 1'b1; flt_kind = 4'(k); flt_pc = pc; flt_vaddr = va;
        flt_insn = insn; flt_flags = fl; flt_pte_load = pte; flt_prefetch = pf;
        reg_we = we; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        #1;
        chk("R3 redirect high", 32'(redirect_o), 32'd1);
        chk("R2 entry pc", redirect_pc_o, base_v + vec_of(k));
        exp_cnt[k]++;
        @(negedge clk);
        flt_valid = 1'b0; flt_pte_load = 1'b0; flt_prefetch = 1'b0; reg_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 redirect low", 32'(redirect_o), 32'd0);
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d);
            chk("R1 reset value", d, 32'd0);
        end
    endtask

    task automatic t_regport;
        logic [31:0] d;
        base_v = 32'h0010_0000; dptb_v = 32'h2000_0000; iptb_v = 32'h3000_0000;
        wr(5'd0, base_v); wr(5'd5, dptb_v); wr(5'd8, iptb_v);
        wr(5'd6, 32'hCAFE_0000);
        rd(5'd0, d); chk("R11 base readback", d, base_v);
        rd(5'd5, d); chk("R11 dptb readback", d, dptb_v);
        rd(5'd8, d); chk("R11 iptb readback", d, iptb_v);
        rd(5'd6, d); chk("R11 itag readback", d, 32'hCAFE_0000);
    endtask

    task automatic t_sweep;
        logic [31:0] d, pc;
        for (int k = 0; k < 16; k++) begin
            pc = 32'h0001_0000 + 32'(k) * 16;
            do_fault(k, pc, 32'h0);
            rd(5'd1, d);
            chk(skip_of(k) ? "R5 trap return" : "R4 return addr", d, pc + (skip_of(k) ? 32'd4 : 32'd0));
        end
        @(posedge clk); #1;
        chk("R3 redirect one cycle", 32'(redirect_o), 32'd0);
    endtask

    task automatic t_return_rules;
        logic [31:0] d;
        wr(5'd1, 32'h0000_5550);
        do_fault(1, 32'h0000_8001);
        rd(5'd1, d); chk("R4 misaligned non-restart keeps", d, 32'h5550);
        do_fault(0, 32'h0000_9002);
        rd(5'd1, d); chk("R4 restart loads misaligned pc", d, 32'h9002);
        do_fault(15, 32'h0000_A003);
        rd(5'd1, d); chk("R5 trap keeps old plus 4", d, 32'h9006);
        do_fault(12, 32'h0000_B000);
        rd(5'd1, d); chk("R5 aligned trap plus 4", d, 32'hB004);
    endtask

    task automatic t_data_capture;
        logic [31:0] d, va, insn, stat;
        va = 32'h1234_5678;
        insn = (32'h29 << 26) | (32'h07 << 21) | 32'h0001_ABCD;
        stat = (32'h29 << 11) | (32'h07 << 6) | 32'h2D;
        do_fault(4, 32'h0004_0000, va, insn, 6'h2D);
        rd(5'd2, d); chk("R6 data va", d, va);
        rd(5'd3, d); chk("R6 status pack", d, stat);
        rd(5'd4, d); chk("R7 data form", d, dptb_v | ((va >> 13) << 3));
        do_fault(7, 32'h0004_0010, 32'h7777_0000, 32'hFFFF_FFFF, 6'h3F, 1'b1, 1'b0);
        rd(5'd2, d); chk("R8 pte load keeps va", d, va);
        rd(5'd3, d); chk("R8 pte load keeps status", d, stat);
        do_fault(8, 32'h0004_0020, 32'h6666_0000, 32'hFFFF_FFFF, 6'h3F, 1'b0, 1'b1);
        rd(5'd2, d); chk("R8 prefetch keeps va", d, va);
        rd(5'd4, d); chk("R8 prefetch keeps form", d, dptb_v | ((va >> 13) << 3));
        do_fault(6, 32'h0004_0030, 32'h0ABC_DEF0, 32'h0, 6'h01);
        rd(5'd2, d); chk("R6 unaligned captures va", d, 32'h0ABC_DEF0);
        rd(5'd3, d); chk("R6 unaligned status", d, 32'h1);
    endtask

    task automatic t_inst_capture;
        logic [31:0] d, pc;
        pc = 32'h0040_6004;
        do_fault(3, pc);
        rd(5'd6, d); chk("R9 itag", d, pc);
        rd(5'd7, d); chk("R9 iform", d, iptb_v | ((pc >> 13) << 3));
        do_fault(9, 32'h0055_0000, 32'h9999_0000, 32'hFFFF_FFFF, 6'h3F);
        rd(5'd6, d); chk("R12 mchk keeps itag", d, pc);
        rd(5'd2, d); chk("R12 mchk keeps dva", d, 32'h0ABC_DEF0);
        rd(5'd3, d); chk("R12 mchk keeps status", d, 32'h1);
    endtask

    task automatic t_collision_counters;
        logic [31:0] d;
        do_fault(10, 32'h0066_0000, 0, 0, 0, 0, 0, 1'b1, 5'd0, 32'hDEAD_0000);
        rd(5'd0, d); chk("R11 write dropped on fault", d, base_v);
        wr(5'd16, 32'h0000_00FF);
        for (int k = 0; k < 16; k++) begin
            rd(5'(16 + k), d);
            chk("R10 event count", d, 32'(exp_cnt[k]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) exp_cnt[k] = 0;
        base_v = '0; dptb_v = '0; iptb_v = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regport();
        t_sweep();
        t_return_rules();
        t_data_capture();
        t_inst_capture();
        t_collision_counters();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule